// File: doc/BRIEF.md
# Gated Decimal Event Tally

This block accumulates single-cycle event strobes into a chain of binary-coded-decimal digits and keeps the running total visible for readout at all times. It is used wherever a count must be read directly as decimal digits, for example when one timing unit opens a counting window and this block tallies what arrives inside it.

Whether a strobe is counted depends on a counting gate built from three sources. The first is a manual run/stop level. The second is an external gate level, which only matters when an accompanying flag says that an external gate source is attached. The third is the synchronous active-low reset.

The top digit wrapping from nine back to zero latches a sticky overflow flag, which only reset clears. Every such wrap, including repeated ones, also produces a single-cycle overflow pulse. All digits advance on the same clock edge through a synchronous carry chain, so no digit lags another.

Top module: `gated_bcd_tally`

## Requirements
- R1: `bcd_value` holds NUM_DECADES digits of 4 bits each. Digit i sits at bits [4i+3:4i], digit 0 is the least significant, and every digit stays in the range 0 to 9.
- R2: A strobe on `event_stb` in a cycle with the gate open raises the decimal value of `bcd_value` by exactly one at the next rising clock edge. A digit at 9 wraps to 0 and advances the next digit on that same edge.
- R3: `gate_open` follows its inputs combinationally. It is high exactly when `rst_n` is high, `run_en` is high, and either `ext_attached` is low or `ext_gate_lvl` is high.
- R4: A strobe in a cycle with the gate closed is ignored, and `bcd_value` holds its value.
- R5: While `ext_attached` is low, `ext_gate_lvl` has no effect on counting or on `gate_open`.
- R6: A clock edge with `rst_n` low clears `bcd_value`, `ovf_flag` and `ovf_pulse`. While `rst_n` is low, `gate_open` is low and strobes are not counted.
- R7: A counted strobe when every digit is 9 wraps `bcd_value` to all zeros and sets `ovf_flag`. The flag stays set until a reset.
- R8: Every wrap of the top digit raises `ovf_pulse` for exactly one clock, in the same cycle that `bcd_value` first reads all zeros. This holds for every wrap, not only the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also closes the gate |
| event_stb | input | 1 | One-cycle event strobe |
| run_en | input | 1 | Manual run (1) / stop (0) control |
| ext_gate_lvl | input | 1 | External gate level, high means open |
| ext_attached | input | 1 | High when an external gate source is attached |
| bcd_value | output | 4*NUM_DECADES | Decimal count, least significant digit in the low bits |
| gate_open | output | 1 | High while strobes are allowed through |
| ovf_flag | output | 1 | Sticky overflow flag, cleared only by reset |
| ovf_pulse | output | 1 | One-clock pulse on every top-digit wrap |

## Verification
The bench exercises the gate with each combination of run/stop, attached flag and external level. It checks that the external level only matters when the attached flag is high and that a stopped control blocks strobes. Dense strobe bursts drive carries through every digit and force the top digit to wrap twice. These bursts separate the sticky flag from the repeating pulse. Random mixes of strobes, gate inputs and occasional resets are compared cycle by cycle with a decimal model, and they catch wrong carry timing, counting while closed, and a reset that fails to clear or to block.

// File: rtl/gated_bcd_tally_pkg.sv
// Shared constants and types for the gated decimal tally.
// Assumes 4-bit BCD digits; the digit limit is the last legal value.
package gated_bcd_tally_pkg;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_LAST = 4'd9;
    typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/tally_gate_qual.sv
// Counting gate qualifier: combines run/stop, optional external gate and
// reset into the open indication and the per-cycle count strobe.
// Assumes all inputs are synchronous to the system clock.
module tally_gate_qual (
    input  logic rst_n,
    input  logic run_en,
    input  logic ext_gate_lvl,
    input  logic ext_attached,
    input  logic event_stb,
    output logic gate_open,
    output logic count_fire
);
    logic ext_ok;

    // External gate only restricts counting when a source is attached.
    always_comb ext_ok = !ext_attached || ext_gate_lvl;

    // Gate opens when running, not in reset and the external gate allows it.
    always_comb gate_open = rst_n && run_en && ext_ok;

    // A strobe is counted only through an open gate.
    always_comb count_fire = gate_open && event_stb;
endmodule

// File: rtl/tally_decade.sv
// One decimal digit of the tally: advances on inc_in, wraps 9 -> 0 and
// reports a carry in the same cycle so all digits update on one edge.
// Assumes synchronous active-low reset.
module tally_decade
    import gated_bcd_tally_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc_in,
    output bcd_digit_t digit,
    output logic       carry_out
);
    logic at_last;

    // Detect the last legal decimal value.
    always_comb at_last = (digit == DIGIT_LAST);

    // Carry propagates combinationally when this digit wraps.
    always_comb carry_out = inc_in && at_last;

    // Digit register: clear on reset, step or wrap on increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit <= '0;
        end else if (inc_in) begin
            digit <= at_last ? '0 : bcd_digit_t'(digit + 1'b1);
        end
    end
endmodule

// File: rtl/tally_overflow.sv
// Overflow tracking: sticky flag set on the first top-digit wrap and a
// one-clock pulse registered on every wrap. Synchronous active-low reset.
module tally_overflow (
    input  logic clk,
    input  logic rst_n,
    input  logic top_wrap,
    output logic ovf_flag,
    output logic ovf_pulse
);
    // Sticky flag: set by any wrap, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (top_wrap) begin
            ovf_flag <= 1'b1;
        end
    end

    // Pulse register: mirrors each wrap for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= top_wrap;
        end
    end
endmodule

// File: rtl/gated_bcd_tally.sv
// Gated decimal event tally: NUM_DECADES BCD digits with a synchronous
// carry chain, a three-source counting gate and overflow reporting.
// Assumes one-cycle event strobes synchronous to clk and a synchronous
// active-low reset.
module gated_bcd_tally
    import gated_bcd_tally_pkg::*;
#(
    parameter int NUM_DECADES = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         event_stb,
    input  logic                         run_en,
    input  logic                         ext_gate_lvl,
    input  logic                         ext_attached,
    output logic [DIGIT_W*NUM_DECADES-1:0] bcd_value,
    output logic                         gate_open,
    output logic                         ovf_flag,
    output logic                         ovf_pulse
);
    localparam int VALUE_W = DIGIT_W * NUM_DECADES;

    logic                 count_fire;
    logic [NUM_DECADES:0] chain;

    tally_gate_qual u_gate (
        .rst_n        (rst_n),
        .run_en       (run_en),
        .ext_gate_lvl (ext_gate_lvl),
        .ext_attached (ext_attached),
        .event_stb    (event_stb),
        .gate_open    (gate_open),
        .count_fire   (count_fire)
    );

    // Chain entry: the qualified strobe feeds the least significant digit.
    always_comb chain[0] = count_fire;

    for (genvar d = 0; d < NUM_DECADES; d++) begin : g_decade
        bcd_digit_t dig;
        tally_decade u_dec (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_in    (chain[d]),
            .digit     (dig),
            .carry_out (chain[d+1])
        );
        // Place this digit into its nibble of the output value.
        always_comb bcd_value[d*DIGIT_W +: DIGIT_W] = dig;
    end

    tally_overflow u_ovf (
        .clk       (clk),
        .rst_n     (rst_n),
        .top_wrap  (chain[NUM_DECADES]),
        .ovf_flag  (ovf_flag),
        .ovf_pulse (ovf_pulse)
    );

    // Width guard kept local to the top.
    if (VALUE_W != $bits(bcd_value)) begin : g_bad_width
        initial $error("value width mismatch");
    end
endmodule

// File: rtl/gated_bcd_tally_checker.sv
// Property checker for the gated decimal tally, attached by bind.
module gated_bcd_tally_checker
    import gated_bcd_tally_pkg::*;
#(
    parameter int NUM_DECADES = 6
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           event_stb,
    input logic                           run_en,
    input logic                           ext_gate_lvl,
    input logic                           ext_attached,
    input logic [DIGIT_W*NUM_DECADES-1:0] bcd_value,
    input logic                           gate_open,
    input logic                           ovf_flag,
    input logic                           ovf_pulse
);
    localparam logic [DIGIT_W*NUM_DECADES-1:0] ALL_NINES = {NUM_DECADES{DIGIT_LAST}};

    for (genvar d = 0; d < NUM_DECADES; d++) begin : g_dig
        assert_digit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            bcd_value[d*DIGIT_W +: DIGIT_W] <= DIGIT_LAST);
    end

    assert_count_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && event_stb && bcd_value != ALL_NINES) |=> (bcd_value != $past(bcd_value)));

    assert_open_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> run_en);

    assert_closed_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open) |=> $stable(bcd_value));

    assert_reset_clears_R6: assert property (@(posedge clk)
        (!rst_n) |=> (bcd_value == '0 && !ovf_flag && !ovf_pulse));

    assert_reset_closes_R6: assert property (@(posedge clk)
        (!rst_n) |-> !gate_open);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (ovf_flag && bcd_value == '0));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);
endmodule

bind gated_bcd_tally gated_bcd_tally_checker #(.NUM_DECADES(NUM_DECADES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .event_stb    (event_stb),
    .run_en       (run_en),
    .ext_gate_lvl (ext_gate_lvl),
    .ext_attached (ext_attached),
    .bcd_value    (bcd_value),
    .gate_open    (gate_open),
    .ovf_flag     (ovf_flag),
    .ovf_pulse    (ovf_pulse)
);

// File: tb/gated_bcd_tally_bench.sv
`timescale 1ns/1ps
module gated_bcd_tally_bench;
    localparam int NDEC = 3;
    localparam int VW = 4 * NDEC;
    localparam int MODV = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          event_stb = 1'b0;
    logic          run_en = 1'b0;
    logic          ext_gate_lvl = 1'b0;
    logic          ext_attached = 1'b0;
    logic [VW-1:0] bcd_value;
    logic          gate_open;
    logic          ovf_flag;
    logic          ovf_pulse;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int          m_cnt = 0;
    logic        m_flag = 1'b0;
    logic        m_pulse = 1'b0;

    gated_bcd_tally #(.NUM_DECADES(NDEC)) u_gated_bcd_tally (
        .clk (clk), .rst_n (rst_n), .event_stb (event_stb), .run_en (run_en),
        .ext_gate_lvl (ext_gate_lvl), .ext_attached (ext_attached),
        .bcd_value (bcd_value), .gate_open (gate_open),
        .ovf_flag (ovf_flag), .ovf_pulse (ovf_pulse)
    );

    always #2 clk = ~clk;

    function automatic logic [VW-1:0] to_bcd(input int v);
        logic [VW-1:0] r;
        int t;
        t = v;
        for (int i = 0; i < NDEC; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic exp_open(input logic r, input logic run, input logic lvl, input logic att);
        return r && run && (!att || lvl);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, check gate then the registered outputs.
    task automatic step(input logic r, input logic run, input logic lvl,
                        input logic att, input logic stb, input string tag);
        logic op;
        @(negedge clk);
        rst_n = r; run_en = run; ext_gate_lvl = lvl; ext_attached = att; event_stb = stb;
        op = exp_open(r, run, lvl, att);
        #1;
        chk(r ? tag : "R6", "gate_open", 32'(gate_open), 32'(op));
        @(posedge clk);
        if (!r) begin
            m_cnt = 0; m_flag = 1'b0; m_pulse = 1'b0;
        end else if (op && stb) begin
            if (m_cnt == MODV - 1) begin
                m_cnt = 0; m_flag = 1'b1; m_pulse = 1'b1;
            end else begin
                m_cnt++; m_pulse = 1'b0;
            end
        end else begin
            m_pulse = 1'b0;
        end
        #1;
        chk(tag, "bcd_value", 32'(bcd_value), 32'(to_bcd(m_cnt)));
        chk(tag, "ovf_flag", 32'(ovf_flag), 32'(m_flag));
        chk(tag, "ovf_pulse", 32'(ovf_pulse), 32'(m_pulse));
        for (int i = 0; i < NDEC; i++)
            if (bcd_value[4*i +: 4] > 4'd9) chk("R1", "digit range", 32'(bcd_value[4*i +: 4]), 32'd9);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        int pulses;
        seed_dummy = $urandom(32'd4242);
        // Reset state (R6), strobes offered during reset.
        step(0, 1, 1, 0, 1, "R6");
        step(0, 1, 1, 0, 1, "R6");
        // Basic counting with no external gate (R2, R1).
        for (int i = 0; i < 25; i++) step(1, 1, 0, 0, 1, "R2");
        // External gate attached and low: closed (R3, R4).
        for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 1, "R4");
        // External gate attached and high: open (R3).
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 1, "R3");
        // Not attached, level toggling has no effect (R5).
        for (int i = 0; i < 6; i++) step(1, 1, 1'(i % 2), 0, 1, "R5");
        // Stopped: ignored (R4).
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 1, "R4");
        // Reset mid-count with a strobe present (R6).
        step(0, 1, 1, 1, 1, "R6");
        step(1, 1, 1, 1, 0, "R6");
        // Random mix (R2, R3, R4).
        for (int i = 0; i < 3000; i++) begin
            logic r;
            r = ($urandom % 100) != 0;
            step(r, 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0), "R3");
        end
        // Drive through two full wraps (R7, R8).
        pulses = 0;
        for (int i = 0; i < 2 * MODV + 10; i++) begin
            step(1, 1, 0, 0, 1, "R8");
            if (ovf_pulse) pulses++;
        end
        chk("R8", "pulse count", 32'(pulses), 32'(m_pulse ? 3 : 2) - 32'(m_pulse ? 1 : 0));
        chk("R7", "flag sticky", 32'(ovf_flag), 32'd1);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 1, "R7");
        step(0, 1, 0, 0, 0, "R6");
        chk("R6", "flag cleared", 32'(ovf_flag), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule